// File: doc/BRIEF.md
# Receive Descriptor Poll Scheduler

This block decides when a receive buffer engine should fetch the next descriptor from its ring in memory. Three things feed the decision. The first is a down-counting poll-interval timer. The second is a sticky demand bit that the host sets. The third is a host bit that switches interval polling off. When the block decides that a fetch is due, it raises a request to the descriptor engine and holds it until the engine acknowledges. An acknowledged fetch clears the demand bit.

The host reaches both control bits through a two-bit write/read port. The demand bit sits at bit 0 and the polling-off bit at bit 1. A receiver-enable input gates all activity. A hard reset clears the control bits. The soft reset and stop inputs only withdraw an outstanding request and restart the timer.

Top module: `rx_poll_sched`

## Requirements
- R1: While `hard_rst` is high, at the next clock edge both control bits (read as `cfg_rd_data` = 2'b00) and `fetch_req` become 0.
- R2: With polling on (bit 1 = 0), `rx_en` = 1 and no demand, `fetch_req` rises exactly N+1 clock edges after the edge that loaded the timer, where N is `poll_reload`. The timer is loaded by the last `hard_rst` edge or by the edge that accepted the previous acknowledge.
- R3: When the demand bit is 1, `rx_en` = 1 and no request is outstanding, `fetch_req` rises at the next edge, whatever the timer holds.
- R4: A write with bit 0 = 1 sets the demand bit. A write with bit 0 = 0 leaves it unchanged. Every write loads bit 1 into the polling-off bit.
- R5: An acknowledge (`fetch_ack` while `fetch_req` is high) clears the demand bit. If a write with bit 0 = 1 lands in the same cycle, the demand bit stays 1.
- R6: With the polling-off bit set and no demand, `fetch_req` never rises.
- R7: While `rx_en` is 0, `fetch_req` is 0 one edge later and stays 0, and a pending demand bit is kept. When `rx_en` returns, a held demand raises the request at the next edge.
- R8: `soft_rst` and `stop_rx` leave both control bits unchanged. Each of them withdraws an outstanding request and reloads the timer.
- R9: Once raised, `fetch_req` stays high until it is acknowledged (or withdrawn per R7/R8). Only one request is outstanding at a time. `fetch_ack` while no request is outstanding is ignored.
- R10: Every issued fetch reloads the timer, whether it was demanded or came from the interval. The next interval fetch therefore comes N+1 edges after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Synchronous hard reset, active high; clears control bits |
| soft_rst | input | 1 | Soft reset; withdraws request, reloads timer |
| stop_rx | input | 1 | Stop; withdraws request, reloads timer |
| rx_en | input | 1 | Receiver enabled |
| cfg_wr_en | input | 1 | Control write strobe |
| cfg_wr_data | input | 2 | Bit 0: set demand; bit 1: polling-off value |
| cfg_rd_data | output | 2 | Bit 0: demand bit; bit 1: polling-off bit |
| poll_reload | input | CNT_W | Poll interval reload value N |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_ack | input | 1 | Engine accepts the outstanding request |

## Verification
The properties assume that `hard_rst` is held high from time zero until the first edge. They also assume that `fetch_ack` carries meaning only while `fetch_req` is high, and that the reload value does not change while the bench measures an interval. The stimulus changes `poll_reload` only together with a hard reset. It drives the acknowledge both inside and outside a pending request, to exercise the rule that a stray acknowledge is ignored. All inputs change at the falling edge, so that every input is stable at the edge where the block samples it.

// File: rtl/rx_poll_pkg.sv
package rx_poll_pkg;

    localparam int CTL_W        = 2;
    localparam int DEMAND_POS   = 0;
    localparam int POLL_OFF_POS = 1;

    typedef struct packed {
        logic poll_off;
        logic demand;
    } rxp_ctl_t;

    typedef enum logic [0:0] {
        REQ_IDLE = 1'b0,
        REQ_WAIT = 1'b1
    } rxp_req_state_e;

    function automatic rxp_ctl_t to_ctl(input logic [CTL_W-1:0] raw);
        rxp_ctl_t c;
        c.demand   = raw[DEMAND_POS];
        c.poll_off = raw[POLL_OFF_POS];
        return c;
    endfunction

    function automatic logic [CTL_W-1:0] from_ctl(input rxp_ctl_t c);
        logic [CTL_W-1:0] raw;
        raw[DEMAND_POS]   = c.demand;
        raw[POLL_OFF_POS] = c.poll_off;
        return raw;
    endfunction

endpackage

// File: rtl/rx_poll_ctl_regs.sv
module rx_poll_ctl_regs
    import rx_poll_pkg::*;
(
    input  logic             clk,
    input  logic             hard_rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             fetch_done,
    output rxp_ctl_t         ctl
);

    rxp_ctl_t wr_fields;

    always_comb begin
        wr_fields = to_ctl(wr_data);
    end

    always_ff @(posedge clk) begin
        if (hard_rst) begin
            ctl <= '0;
        end else begin
            if (wr_en) begin
                ctl.poll_off <= wr_fields.poll_off;
            end
            if (wr_en && wr_fields.demand) begin
                ctl.demand <= 1'b1;
            end else if (fetch_done) begin
                ctl.demand <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rx_poll_timer.sv
module rx_poll_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             hard_rst,
    input  logic             restart,
    input  logic             reload_now,
    input  logic             count_en,
    input  logic [CNT_W-1:0] reload_val,
    output logic             expired
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (hard_rst || restart || reload_now) begin
            cnt <= reload_val;
        end else if (count_en && (cnt != CNT_ZERO)) begin
            cnt <= cnt - CNT_ONE;
        end
    end

    assign expired = (cnt == CNT_ZERO);

endmodule

// File: rtl/rx_poll_req.sv
module rx_poll_req
    import rx_poll_pkg::*;
(
    input  logic clk,
    input  logic hard_rst,
    input  logic cancel,
    input  logic want,
    input  logic ack,
    output logic req,
    output logic issue,
    output logic done
);

    rxp_req_state_e state;

    always_ff @(posedge clk) begin
        if (hard_rst || cancel) begin
            state <= REQ_IDLE;
        end else begin
            unique case (state)
                REQ_IDLE: if (want) state <= REQ_WAIT;
                REQ_WAIT: if (ack)  state <= REQ_IDLE;
                default:            state <= REQ_IDLE;
            endcase
        end
    end

    assign req   = (state == REQ_WAIT);
    assign issue = (state == REQ_IDLE) && want && !cancel;
    assign done  = req && ack;

endmodule

// File: rtl/rx_poll_sched.sv
module rx_poll_sched
    import rx_poll_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             hard_rst,
    input  logic             soft_rst,
    input  logic             stop_rx,
    input  logic             rx_en,
    input  logic             cfg_wr_en,
    input  logic [1:0]       cfg_wr_data,
    output logic [1:0]       cfg_rd_data,
    input  logic [CNT_W-1:0] poll_reload,
    output logic             fetch_req,
    input  logic             fetch_ack
);

    rxp_ctl_t ctl;
    logic     restart;
    logic     cancel;
    logic     expired;
    logic     want;
    logic     issue;
    logic     done;
    logic     count_en;

    assign restart  = soft_rst || stop_rx;
    assign cancel   = restart || !rx_en;
    assign want     = rx_en && (ctl.demand || (!ctl.poll_off && expired));
    assign count_en = rx_en && !ctl.poll_off && !fetch_req;

    rx_poll_ctl_regs u_regs (
        .clk        (clk),
        .hard_rst   (hard_rst),
        .wr_en      (cfg_wr_en),
        .wr_data    (cfg_wr_data),
        .fetch_done (done),
        .ctl        (ctl)
    );

    rx_poll_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .hard_rst   (hard_rst),
        .restart    (restart),
        .reload_now (issue),
        .count_en   (count_en),
        .reload_val (poll_reload),
        .expired    (expired)
    );

    rx_poll_req u_req (
        .clk      (clk),
        .hard_rst (hard_rst),
        .cancel   (cancel),
        .want     (want),
        .ack      (fetch_ack),
        .req      (fetch_req),
        .issue    (issue),
        .done     (done)
    );

    assign cfg_rd_data = from_ctl(ctl);

endmodule

// File: rtl/rx_poll_sched_chk.sv
module rx_poll_sched_chk (
    input logic       clk,
    input logic       hard_rst,
    input logic       soft_rst,
    input logic       stop_rx,
    input logic       rx_en,
    input logic       cfg_wr_en,
    input logic [1:0] cfg_wr_data,
    input logic [1:0] cfg_rd_data,
    input logic       fetch_req,
    input logic       fetch_ack
);

    p_hold_req_r9: assert property (@(posedge clk) disable iff (hard_rst)
        fetch_req && !fetch_ack && rx_en && !soft_rst && !stop_rx |=> fetch_req);

    p_rx_off_quiet_r7: assert property (@(posedge clk) disable iff (hard_rst)
        !rx_en |=> !fetch_req);

    p_demand_issue_r3: assert property (@(posedge clk) disable iff (hard_rst)
        cfg_rd_data[0] && rx_en && !fetch_req && !soft_rst && !stop_rx |=> fetch_req);

    p_write_set_r4: assert property (@(posedge clk) disable iff (hard_rst)
        cfg_wr_en && cfg_wr_data[0] |=> cfg_rd_data[0]);

    p_poll_off_load_r4: assert property (@(posedge clk) disable iff (hard_rst)
        cfg_wr_en |=> cfg_rd_data[1] == $past(cfg_wr_data[1]));

    p_ack_clears_r5: assert property (@(posedge clk) disable iff (hard_rst)
        fetch_req && fetch_ack && !(cfg_wr_en && cfg_wr_data[0]) |=> !cfg_rd_data[0]);

    p_demand_steady_r5: assert property (@(posedge clk) disable iff (hard_rst)
        !(cfg_wr_en && cfg_wr_data[0]) && !(fetch_req && fetch_ack)
        |=> cfg_rd_data[0] == $past(cfg_rd_data[0]));

    p_no_auto_r6: assert property (@(posedge clk) disable iff (hard_rst)
        cfg_rd_data[1] && !cfg_rd_data[0] && !fetch_req |=> !fetch_req);

    p_bits_keep_r8: assert property (@(posedge clk) disable iff (hard_rst)
        !cfg_wr_en && !fetch_ack |=> $stable(cfg_rd_data));

    p_withdraw_r8: assert property (@(posedge clk) disable iff (hard_rst)
        soft_rst || stop_rx |=> !fetch_req);

endmodule

bind rx_poll_sched rx_poll_sched_chk u_chk (
    .clk         (clk),
    .hard_rst    (hard_rst),
    .soft_rst    (soft_rst),
    .stop_rx     (stop_rx),
    .rx_en       (rx_en),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data),
    .fetch_req   (fetch_req),
    .fetch_ack   (fetch_ack)
);

// File: tb/rx_poll_sched_tb_top.sv
`timescale 1ns/1ps
module rx_poll_sched_tb_top;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             hard_rst = 1'b1;
    logic             soft_rst = 1'b0;
    logic             stop_rx = 1'b0;
    logic             rx_en = 1'b0;
    logic             cfg_wr_en = 1'b0;
    logic [1:0]       cfg_wr_data = 2'b00;
    logic [1:0]       cfg_rd_data;
    logic [CNT_W-1:0] poll_reload = '0;
    logic             fetch_req;
    logic             fetch_ack = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rx_poll_sched #(.CNT_W(CNT_W)) dut_i (
        .clk         (clk),
        .hard_rst    (hard_rst),
        .soft_rst    (soft_rst),
        .stop_rx     (stop_rx),
        .rx_en       (rx_en),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_data (cfg_rd_data),
        .poll_reload (poll_reload),
        .fetch_req   (fetch_req),
        .fetch_ack   (fetch_ack)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_req(output int k);
        k = 0;
        for (int i = 0; i < 200; i++) begin
            step();
            k++;
            if (fetch_req) break;
        end
    endtask

    task automatic cfg_write(input logic [1:0] v);
        cfg_wr_en = 1'b1;
        cfg_wr_data = v;
        step();
        cfg_wr_en = 1'b0;
        cfg_wr_data = 2'b00;
    endtask

    task automatic do_ack();
        fetch_ack = 1'b1;
        step();
        fetch_ack = 1'b0;
    endtask

    task automatic hard_pulse();
        hard_rst = 1'b1;
        step();
        hard_rst = 1'b0;
    endtask

    initial begin
        int k;
        int seen;
        step();
        step();
        chk(cfg_rd_data == 2'b00, "R1 bits after reset", cfg_rd_data, 0);
        chk(fetch_req == 1'b0, "R1 req after reset", fetch_req, 0);
        hard_rst = 1'b0;

        rx_en = 1'b1;
        for (int n = 0; n < 8; n++) begin
            poll_reload = CNT_W'(n);
            hard_pulse();
            wait_req(k);
            chk(k == n + 1, "R2 interval after reset", k, n + 1);
            if (n == 2) begin
                step(); step(); step();
                chk(fetch_req == 1'b1, "R9 request held", fetch_req, 1);
            end
            do_ack();
            chk(fetch_req == 1'b0, "R9 request dropped on ack", fetch_req, 0);
            wait_req(k);
            chk(k == n + 1, "R2 interval after ack", k, n + 1);
            do_ack();
        end

        poll_reload = CNT_W'(3);
        hard_pulse();
        cfg_write(2'b10);
        chk(cfg_rd_data == 2'b10, "R4 poll-off loaded", cfg_rd_data, 2);
        seen = 0;
        for (int i = 0; i < 30; i++) begin
            step();
            if (fetch_req) seen++;
        end
        chk(seen == 0, "R6 no automatic poll", seen, 0);

        cfg_write(2'b11);
        chk(cfg_rd_data == 2'b11, "R4 demand set", cfg_rd_data, 3);
        chk(fetch_req == 1'b0, "R3 not before next edge", fetch_req, 0);
        step();
        chk(fetch_req == 1'b1, "R3 demanded fetch", fetch_req, 1);
        cfg_write(2'b10);
        chk(cfg_rd_data == 2'b11, "R4 write 0 keeps demand", cfg_rd_data, 3);
        do_ack();
        chk(cfg_rd_data == 2'b10, "R5 ack clears demand", cfg_rd_data, 2);
        step(); step();
        chk(fetch_req == 1'b0, "R6 quiet after demand served", fetch_req, 0);

        cfg_write(2'b11);
        step();
        chk(fetch_req == 1'b1, "R3 second demand", fetch_req, 1);
        fetch_ack = 1'b1;
        cfg_wr_en = 1'b1;
        cfg_wr_data = 2'b11;
        step();
        fetch_ack = 1'b0;
        cfg_wr_en = 1'b0;
        chk(cfg_rd_data[0] == 1'b1, "R5 demand kept on same-cycle write", cfg_rd_data[0], 1);
        chk(fetch_req == 1'b0, "R9 ack accepted", fetch_req, 0);
        step();
        chk(fetch_req == 1'b1, "R5 kept demand reissues", fetch_req, 1);
        do_ack();
        chk(cfg_rd_data == 2'b10, "R5 cleared after second ack", cfg_rd_data, 2);

        rx_en = 1'b0;
        cfg_write(2'b11);
        do_ack();
        chk(cfg_rd_data == 2'b11, "R9 stray ack ignored", cfg_rd_data, 3);
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            step();
            if (fetch_req) seen++;
        end
        chk(seen == 0, "R7 no request while disabled", seen, 0);
        chk(cfg_rd_data[0] == 1'b1, "R7 demand held while disabled", cfg_rd_data[0], 1);
        rx_en = 1'b1;
        step();
        chk(fetch_req == 1'b1, "R7 held demand served", fetch_req, 1);
        rx_en = 1'b0;
        step();
        chk(fetch_req == 1'b0, "R7 request withdrawn", fetch_req, 0);

        soft_rst = 1'b1;
        step();
        soft_rst = 1'b0;
        chk(cfg_rd_data == 2'b11, "R8 soft reset keeps bits", cfg_rd_data, 3);
        stop_rx = 1'b1;
        step();
        stop_rx = 1'b0;
        chk(cfg_rd_data == 2'b11, "R8 stop keeps bits", cfg_rd_data, 3);
        rx_en = 1'b1;
        step();
        chk(fetch_req == 1'b1, "R8 request before stop", fetch_req, 1);
        stop_rx = 1'b1;
        step();
        stop_rx = 1'b0;
        chk(fetch_req == 1'b0, "R8 stop withdraws request", fetch_req, 0);
        step();
        chk(fetch_req == 1'b1, "R8 demand survives stop", fetch_req, 1);
        rx_en = 1'b0;
        hard_pulse();
        chk(cfg_rd_data == 2'b00, "R1 hard reset clears bits", cfg_rd_data, 0);

        poll_reload = CNT_W'(20);
        rx_en = 1'b1;
        hard_pulse();
        step(); step(); step();
        cfg_write(2'b01);
        step();
        chk(fetch_req == 1'b1, "R3 demand hastens poll", fetch_req, 1);
        do_ack();
        wait_req(k);
        chk(k == 21, "R10 timer reloaded by demanded fetch", k, 21);
        do_ack();

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule